// File: doc/BRIEF.md
# DRAM Strobe-Order Cycle Decoder with Refresh Row Counter

This block is the control logic that sits on the device side of a small dynamic memory. A fast on-chip clock samples four asynchronous active-low strobes: row strobe, column strobe, write strobe and output-enable. Each strobe passes through a two-flop synchronizer and an edge detector. The block then works out which kind of memory cycle is running from the order in which the strobe edges arrive. No command code is involved. The block latches row and column addresses, moves data to and from a small behavioural cell array, and decides when the data bus is driven.

A falling row strobe while the column strobe is already low starts a column-before-row refresh. In that case an internal row counter chooses the row to refresh, and the counter then advances. If a read has left data on the bus, the same sequence becomes a hidden refresh and the data stays on the bus. The block reports every refreshed row on a bookkeeping output, so that counter order and wraparound can be checked.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After a synchronous active-low reset, `dout_en` is 0, `cycle_kind` is 0 (idle), `refresh_row` is 0 and the internal refresh counter is 0.
- R2: A read occurs when the column strobe falls while the row strobe is low, the write strobe is high and output-enable is low. By the third rising clock edge after that edge, `dout_en` is 1, `dout` holds the word stored at the latched row and column, and `cycle_kind` is 1.
- R3: If the write strobe is already low when the column strobe falls, the cycle is an early write. `din` at that edge is stored, `cycle_kind` becomes 2, and `dout_en` stays 0 for the whole cycle.
- R4: If the write strobe falls after the column strobe, with output-enable high, the cycle is a late write. `din` at the write-strobe edge is stored, `cycle_kind` becomes 3, and `dout_en` stays 0.
- R5: If the row strobe falls while the column strobe is high, the row on `addr` is latched and reported on `refresh_row`. `cycle_kind` becomes 4 and `dout_en` stays 0. Every read or write cycle begins this way, so it also refreshes its addressed row.
- R6: If the row strobe falls while the column strobe is low and no read data is being driven, the cycle is a counter refresh. `refresh_row` takes the counter value, and `addr` has no effect on it. The counter then advances by one modulo 2^ADDR_W. `cycle_kind` becomes 5 and `dout_en` stays 0.
- R7: Suppose that after a read the column strobe stays low, and the row strobe rises and then falls again. This is a hidden refresh. `cycle_kind` becomes 6, the counter refresh of R6 takes place, and `dout`/`dout_en` keep the read word.
- R8: Once the row and column strobes are both high, `dout_en` is 0 and `cycle_kind` is 0 (idle) by the third rising clock edge.
- R9: If output-enable is high when the column strobe falls with the write strobe high, `cycle_kind` becomes 7 (column open) and nothing is driven. A later fall of output-enable starts the read of R2.
- R10: With the row strobe held low, each new fall of the column strobe latches a new column. A read then returns the word at that column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, much faster than the strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Multiplexed row/column address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Read data |
| dout_en | output | 1 | High when the data bus is driven |
| cycle_kind | output | 3 | Decoded cycle: 0 idle, 1 read, 2 early write, 3 late write, 4 row-only refresh, 5 counter refresh, 6 hidden refresh, 7 column open |
| refresh_row | output | ADDR_W | Most recently refreshed row |

## Verification
The assertions assume that each strobe level lasts several clock periods, so the synchronizer sees every edge. They also assume that `addr` and `din` are stable from before a strobe edge until that edge has been detected, and that output-enable stays low through a hidden refresh. The bench changes inputs only on falling clock edges. It sets the address and data before each strobe change, and it waits four clock periods after every strobe change before it samples or moves anything else.

// File: rtl/dram_dec_pkg.sv
// Shared types for the strobe-order cycle decoder.
package dram_dec_pkg;
    // Decoded cycle classification; the codes are visible on cycle_kind.
    typedef enum logic [2:0] {
        CK_IDLE   = 3'd0,
        CK_READ   = 3'd1,
        CK_EWR    = 3'd2,
        CK_LWR    = 3'd3,
        CK_RONLY  = 3'd4,
        CK_CBR    = 3'd5,
        CK_HIDDEN = 3'd6,
        CK_OPEN   = 3'd7
    } cyc_kind_e;
endpackage

// File: rtl/dds_sync_edge.sv
// Two-flop synchronizer and falling-edge detector for N active-low strobes.
// Assumes: each strobe level lasts at least two clock periods.
// Resets to the idle-high level, so no edge is reported after reset.
module dds_sync_edge #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] a_in,
    output logic [N-1:0] lvl,
    output logic [N-1:0] fall
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic meta_q, sync_q, prev_q;
        // Synchronize one strobe and keep its previous synchronized level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b1;
                sync_q <= 1'b1;
                prev_q <= 1'b1;
            end else begin
                meta_q <= a_in[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end
        assign lvl[i]  = sync_q;
        assign fall[i] = prev_q & ~sync_q;
    end
endmodule

// File: rtl/dds_refresh_ctr.sv
// Refresh row counter: supplies the row for counter refresh, wraps modulo 2^W.
// Assumes: inc is a single-cycle pulse per refresh cycle.
module dds_refresh_ctr #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Advance by one on each refresh request.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/dds_cell_array.sv
// Behavioural cell array standing in for the storage core.
// Assumes: one write per clock at most; read is combinational.
module dds_cell_array #(
    parameter int AW = 8,
    parameter int DW = 4
) (
    input  logic          clk,
    input  logic          wr,
    input  logic [AW-1:0] a,
    input  logic [DW-1:0] wd,
    output logic [DW-1:0] rd
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] cells [DEPTH];

    // Store a word on a write request.
    always_ff @(posedge clk) begin
        if (wr) cells[a] <= wd;
    end
    assign rd = cells[a];
endmodule

// File: rtl/dram_strobe_decoder.sv
// Device-side control of a small DRAM. Decodes the cycle type from the order of
// synchronized strobe edges, latches row/column addresses, moves data to the
// cell array, steps the refresh row counter and gates the data-bus drive.
// Assumes: strobes are slow relative to clk; addr/din are stable around edges.
module dram_strobe_decoder
    import dram_dec_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_en,
    output logic [2:0]        cycle_kind,
    output logic [ADDR_W-1:0] refresh_row
);
    localparam int CELL_AW = 2 * ADDR_W;

    logic [3:0] lvl, fall;
    logic s_ras, s_cas, s_we, s_oe, f_ras, f_cas, f_we, f_oe;

    dds_sync_edge #(.N(4)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .a_in ({oe_n, we_n, cas_n, ras_n}),
        .lvl  (lvl),
        .fall (fall)
    );
    assign {s_oe, s_we, s_cas, s_ras} = lvl;
    assign {f_oe, f_we, f_cas, f_ras} = fall;

    logic [ADDR_W-1:0] row_q, col_q, cnt;
    logic              col_open_q, wrote_q, cbr_q;
    cyc_kind_e         kind_q;

    logic ev_cbr, ev_rrow, col_ok, ev_cas, ev_ewr, ev_rdc, late_ok, ev_lwr, ev_rdo;
    logic [ADDR_W-1:0] cur_col;
    logic [DATA_W-1:0] rd_word;

    // Classify the strobe events seen in this cycle.
    always_comb begin
        ev_cbr  = f_ras && !s_cas;
        ev_rrow = f_ras && s_cas;
        col_ok  = !s_ras && !cbr_q && !f_ras;
        ev_cas  = f_cas && col_ok;
        ev_ewr  = ev_cas && !s_we;
        ev_rdc  = ev_cas && s_we && !s_oe;
        late_ok = col_open_q && !s_cas && col_ok && !wrote_q && !f_cas;
        ev_lwr  = late_ok && f_we;
        ev_rdo  = late_ok && !f_we && f_oe && s_we;
        cur_col = ev_cas ? addr : col_q;
    end

    dds_refresh_ctr #(.W(ADDR_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (ev_cbr),
        .count(cnt)
    );

    dds_cell_array #(.AW(CELL_AW), .DW(DATA_W)) u_cells (
        .clk(clk),
        .wr (ev_ewr || ev_lwr),
        .a  ({row_q, cur_col}),
        .wd (din),
        .rd (rd_word)
    );

    // Cycle state: address latches, classification and refresh bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q       <= '0;
            col_q       <= '0;
            col_open_q  <= 1'b0;
            wrote_q     <= 1'b0;
            cbr_q       <= 1'b0;
            kind_q      <= CK_IDLE;
            refresh_row <= '0;
        end else if (s_ras && s_cas) begin
            col_open_q <= 1'b0;
            cbr_q      <= 1'b0;
            kind_q     <= CK_IDLE;
        end else if (ev_cbr) begin
            cbr_q       <= 1'b1;
            col_open_q  <= 1'b0;
            refresh_row <= cnt;
            kind_q      <= dout_en ? CK_HIDDEN : CK_CBR;
        end else if (ev_rrow) begin
            row_q       <= addr;
            cbr_q       <= 1'b0;
            col_open_q  <= 1'b0;
            refresh_row <= addr;
            kind_q      <= CK_RONLY;
        end else if (ev_cas) begin
            col_q      <= addr;
            col_open_q <= 1'b1;
            wrote_q    <= ev_ewr;
            kind_q     <= ev_ewr ? CK_EWR : (ev_rdc ? CK_READ : CK_OPEN);
        end else if (ev_lwr) begin
            wrote_q <= 1'b1;
            kind_q  <= CK_LWR;
        end else if (ev_rdo) begin
            kind_q <= CK_READ;
        end
    end

    // Data-bus drive: set by a read, dropped when the column strobe or OE is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= '0;
            dout_en <= 1'b0;
        end else if (ev_rdc || ev_rdo) begin
            dout    <= rd_word;
            dout_en <= 1'b1;
        end else if (s_cas || s_oe) begin
            dout_en <= 1'b0;
        end
    end

    assign cycle_kind = kind_q;
endmodule

// File: rtl/dds_checker.sv
// Assertion checker for dram_strobe_decoder, attached through bind below.
// Assumes: output-enable stays low through a hidden refresh.
module dds_checker
    import dram_dec_pkg::*;
#(
    parameter int AW = 4,
    parameter int DW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_ras,
    input logic          s_cas,
    input logic          s_oe,
    input logic          ev_cbr,
    input logic [2:0]    kind,
    input logic          dout_en,
    input logic [DW-1:0] dout,
    input logic [AW-1:0] cnt
);
    assert_cbr_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        kind == CK_CBR |-> !dout_en);

    assert_ewr_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        kind == CK_EWR |-> !dout_en);

    assert_idle_hiz_R8: assert property (@(posedge clk) disable iff (!rst_n)
        s_ras && s_cas |=> !dout_en);

    assert_ctr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cbr |=> cnt == AW'($past(cnt) + 1'b1));

    assert_hidden_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_cbr && dout_en && !s_oe |=> dout_en && $stable(dout));
endmodule

bind dram_strobe_decoder dds_checker #(.AW(ADDR_W), .DW(DATA_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .s_ras  (s_ras),
    .s_cas  (s_cas),
    .s_oe   (s_oe),
    .ev_cbr (ev_cbr),
    .kind   (cycle_kind),
    .dout_en(dout_en),
    .dout   (dout),
    .cnt    (cnt)
);

// File: tb/tb_dram_strobe_decoder.sv
module tb_dram_strobe_decoder;
    localparam int AW = 4;
    localparam int DW = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_en;
    logic [2:0]    cycle_kind;
    logic [AW-1:0] refresh_row;

    int n_chk = 0, n_err = 0;
    bit done = 0;
    int exp_cnt = 0;

    always #2.5 clk = ~clk;

    dram_strobe_decoder #(.ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
        .cycle_kind(cycle_kind), .refresh_row(refresh_row)
    );

    // op: 0 early write, 1 late write, 2 read (OE low at column edge), 3 read (OE later)
    typedef struct packed {
        logic [1:0]    op;
        logic [AW-1:0] row;
        logic [AW-1:0] col;
        logic [DW-1:0] dat;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd0, 4'd3,  4'd5, 4'hA},
        '{2'd1, 4'd3,  4'd6, 4'h5},
        '{2'd0, 4'd12, 4'd0, 4'hF},
        '{2'd2, 4'd3,  4'd5, 4'hA},
        '{2'd3, 4'd3,  4'd6, 4'h5},
        '{2'd2, 4'd12, 4'd0, 4'hF},
        '{2'd1, 4'd3,  4'd5, 4'h7},
        '{2'd3, 4'd3,  4'd5, 4'h7}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic w4();
        repeat (4) @(negedge clk);
    endtask

    task automatic release_all();
        ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        w4();
        chk(dout_en == 1'b0, "R8 bus off when idle", dout_en, 0);
        chk(cycle_kind == 3'd0, "R8 idle kind", cycle_kind, 0);
    endtask

    task automatic open_row(input logic [AW-1:0] r);
        addr = r; ras_n = 1'b0; w4();
        chk(refresh_row == r, "R5 access refreshes its row", refresh_row, r);
    endtask

    task automatic run_vec(input vec_t v);
        open_row(v.row);
        addr = v.col;
        case (v.op)
            2'd0: begin
                din = v.dat; we_n = 1'b0; w4();
                cas_n = 1'b0; w4();
                chk(cycle_kind == 3'd2, "R3 early write kind", cycle_kind, 2);
                chk(dout_en == 1'b0, "R3 early write no drive", dout_en, 0);
            end
            2'd1: begin
                cas_n = 1'b0; w4();
                chk(cycle_kind == 3'd7, "R9 column open kind", cycle_kind, 7);
                din = v.dat; we_n = 1'b0; w4();
                chk(cycle_kind == 3'd3, "R4 late write kind", cycle_kind, 3);
                chk(dout_en == 1'b0, "R4 late write no drive", dout_en, 0);
            end
            2'd2: begin
                oe_n = 1'b0; cas_n = 1'b0; w4();
                chk(cycle_kind == 3'd1, "R2 read kind", cycle_kind, 1);
                chk(dout_en == 1'b1 && dout == v.dat, "R2 read data", dout, v.dat);
            end
            default: begin
                cas_n = 1'b0; w4();
                chk(dout_en == 1'b0, "R9 no drive before OE", dout_en, 0);
                oe_n = 1'b0; w4();
                chk(cycle_kind == 3'd1, "R9 OE-triggered read kind", cycle_kind, 1);
                chk(dout_en == 1'b1 && dout == v.dat, "R9 OE-triggered read data", dout, v.dat);
            end
        endcase
        release_all();
    endtask

    task automatic cbr(input logic [AW-1:0] junk);
        addr = junk; cas_n = 1'b0; w4();
        ras_n = 1'b0; w4();
        chk(cycle_kind == 3'd5, "R6 counter refresh kind", cycle_kind, 5);
        chk(refresh_row == AW'(exp_cnt), "R6 counter row, addr ignored", refresh_row, exp_cnt);
        chk(dout_en == 1'b0, "R6 no drive", dout_en, 0);
        exp_cnt = (exp_cnt + 1) % (1 << AW);
        release_all();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dout_en == 1'b0, "R1 reset dout_en", dout_en, 0);
        chk(cycle_kind == 3'd0, "R1 reset kind", cycle_kind, 0);
        chk(refresh_row == '0, "R1 reset refresh_row", refresh_row, 0);

        foreach (VEC[i]) run_vec(VEC[i]);

        // R5 row-only refresh
        addr = 4'd9; ras_n = 1'b0; w4();
        chk(cycle_kind == 3'd4, "R5 row-only kind", cycle_kind, 4);
        chk(refresh_row == 4'd9, "R5 row-only row", refresh_row, 9);
        chk(dout_en == 1'b0, "R5 row-only no drive", dout_en, 0);
        release_all();

        // R6 counter refresh sequence with wraparound (R1: counter starts at 0)
        for (int k = 0; k < 18; k++) cbr(AW'(k * 5 + 1));

        // R7 hidden refresh after a read
        open_row(4'd3);
        addr = 4'd6; oe_n = 1'b0; cas_n = 1'b0; w4();
        chk(dout_en == 1'b1 && dout == 4'h5, "R7 read before hidden", dout, 5);
        ras_n = 1'b1; w4();
        chk(dout_en == 1'b1 && dout == 4'h5, "R7 data held across row rise", dout, 5);
        addr = 4'd11; ras_n = 1'b0; w4();
        chk(cycle_kind == 3'd6, "R7 hidden kind", cycle_kind, 6);
        chk(dout_en == 1'b1 && dout == 4'h5, "R7 data held in hidden", dout, 5);
        chk(refresh_row == AW'(exp_cnt), "R7 hidden uses counter", refresh_row, exp_cnt);
        exp_cnt = (exp_cnt + 1) % (1 << AW);
        release_all();
        cbr(4'd2);

        // R10 column change within one row
        open_row(4'd3);
        addr = 4'd5; oe_n = 1'b0; cas_n = 1'b0; w4();
        chk(dout == 4'h7 && dout_en, "R10 first column", dout, 7);
        cas_n = 1'b1; w4();
        chk(dout_en == 1'b0, "R10 bus off between columns", dout_en, 0);
        addr = 4'd6; cas_n = 1'b0; w4();
        chk(dout == 4'h5 && dout_en, "R10 second column", dout, 5);
        release_all();

        done = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule